// File: doc/BRIEF.md
# Gated Counter Frequency Meter

This block measures the frequency of a fast oscillator against a slower reference clock. A single start command in the reference domain clears both counters and starts a measurement. A window counter in the reference domain counts a programmable number of reference cycles, N. During that window an oscillator-domain counter advances once every 16 oscillator cycles, behind a divide-by-16 prescaler. At the end of the window the oscillator counter is frozen. Its value M is carried back into the reference domain and presented with a valid flag. The controller then computes the oscillator frequency as 16·M·f_ref/N.

Both directions of the clock-domain crossing are handled inside the block. The run request reaches the oscillator domain through a two-flop synchroniser. The oscillator side acknowledges each level change through a second synchroniser. The reference side samples the frozen count only after it sees the acknowledge fall, so the count bus never changes while it is sampled. The oscillator is taken to be already squared up as a digital clock.

Top module: `freq_gate_meter`

## Requirements
- R1: While reset is applied and right after it, busy_o, valid_o, ovf_o and m_o are all zero.
- R2: A start_i sampled high at a reference edge while the block is not busy sets busy_o high and valid_o low from that edge on.
- R3: The count m_o lies within 2 of N·T_ref/(16·T_osc), where N is the n_i value sampled with the accepted start and T_ref and T_osc are the two clock periods.
- R4: An n_i of 0 gives the same measurement window as an n_i of 1, so start-to-valid latency for N=0 is within one cycle of that for N=1.
- R5: A start_i sampled while busy_o is high has no effect: busy_o stays high and the result reflects the first window's N.
- R6: If the prescaled count would exceed 2^M_W−1, m_o stays at all ones and ovf_o is 1; otherwise ovf_o is 0.
- R7: valid_o, m_o and ovf_o hold their values until the next accepted start, and valid_o falls at the edge that accepts that start.
- R8: busy_o and valid_o are never high together, and busy_o falls at the same edge where valid_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the control side runs on it |
| osc_clk | input | 1 | Oscillator under measurement, as a digital clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| start_i | input | 1 | Starts a measurement when the block is not busy |
| n_i | input | N_W | Window length in reference cycles, sampled at start |
| busy_o | output | 1 | A measurement is in progress |
| valid_o | output | 1 | m_o and ovf_o hold a finished result |
| m_o | output | M_W | Prescaled oscillator count of the last window |
| ovf_o | output | 1 | The count saturated during the last window |

## Verification
The saturation case is the hardest to reach from the ports. With a 16-bit count it needs about a million oscillator cycles in one window. The bench therefore builds the block with a narrow count width, so that a window of a thousand reference cycles with a fast oscillator overruns the count. A second hard case is a start that arrives in the middle of a window. The bench issues it some cycles after the first start with a window twice as long, then checks that the result still matches the shorter window.

// File: rtl/fgm_pkg.sv
package fgm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_COUNT,
      ST_STOP,
      ST_DONE
   } fgm_state_e;
endpackage

// File: rtl/fgm_sync.sv
module fgm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fgm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fgm_osc_count.sv
module fgm_osc_count #(
   parameter int M_W      = 16,
   parameter int PRE_LOG2 = 4
) (
   input  logic           osc_clk,
   input  logic           rst_n,
   input  logic           run_s_i,
   output logic           active_o,
   output logic [M_W-1:0] count_o,
   output logic           ovf_o
);
   localparam logic [M_W-1:0] M_MAX = '1;

   generate
      if (M_W < 2) begin : g_bad_mw
         $error("fgm_osc_count: M_W must be at least 2");
      end
   endgenerate

   logic active_q;
   logic arm_edge;
   logic tick;

   assign arm_edge = run_s_i && !active_q;

   generate
      if (PRE_LOG2 == 0) begin : g_no_pre
         assign tick = active_q;
      end else begin : g_pre
         logic [PRE_LOG2-1:0] pre_q;
         always_ff @(posedge osc_clk or negedge rst_n) begin
            if (!rst_n)        pre_q <= '0;
            else if (arm_edge) pre_q <= '0;
            else if (active_q) pre_q <= pre_q + 1'b1;
         end
         assign tick = active_q && (pre_q == '1);
      end
   endgenerate

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         count_o  <= '0;
         ovf_o    <= 1'b0;
      end else begin
         active_q <= run_s_i;
         if (arm_edge) begin
            count_o <= '0;
            ovf_o   <= 1'b0;
         end else if (tick) begin
            if (count_o == M_MAX) ovf_o   <= 1'b1;
            else                  count_o <= count_o + 1'b1;
         end
      end
   end

   assign active_o = active_q;

   // R7: outside a window the count does not move
   a_r7_frozen_outside: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (!active_q && !run_s_i) |=> $stable(count_o));

   // R6: the overflow flag only comes up once the count is full
   a_r6_ovf_at_max: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $rose(ovf_o) |-> (count_o == M_MAX));
endmodule

// File: rtl/freq_gate_meter.sv
module freq_gate_meter #(
   parameter int N_W         = 16,
   parameter int M_W         = 16,
   parameter int PRE_LOG2    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic           ref_clk,
   input  logic           osc_clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [N_W-1:0] n_i,
   output logic           busy_o,
   output logic           valid_o,
   output logic [M_W-1:0] m_o,
   output logic           ovf_o
);
   import fgm_pkg::*;

   localparam logic [N_W-1:0] N_ONE = N_W'(1);

   generate
      if (N_W < 2) begin : g_bad_nw
         $error("freq_gate_meter: N_W must be at least 2");
      end
   endgenerate

   fgm_state_e     state_q;
   logic [N_W-1:0] win_cnt_q;
   logic [N_W-1:0] n_lim_q;
   logic           run_q;
   logic           run_s;
   logic           ack_osc;
   logic           ack_s;
   logic [M_W-1:0] m_osc;
   logic           ovf_osc;

   fgm_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
      .clk   (osc_clk),
      .rst_n (rst_n),
      .d_i   (run_q),
      .q_o   (run_s)
   );

   fgm_osc_count #(.M_W(M_W), .PRE_LOG2(PRE_LOG2)) u_osc (
      .osc_clk  (osc_clk),
      .rst_n    (rst_n),
      .run_s_i  (run_s),
      .active_o (ack_osc),
      .count_o  (m_osc),
      .ovf_o    (ovf_osc)
   );

   fgm_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d_i   (ack_osc),
      .q_o   (ack_s)
   );

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         win_cnt_q <= '0;
         n_lim_q   <= N_ONE;
         run_q     <= 1'b0;
         m_o       <= '0;
         ovf_o     <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE, ST_DONE: begin
               if (start_i) begin
                  state_q   <= ST_ARM;
                  n_lim_q   <= (n_i == '0) ? N_ONE : n_i;
                  win_cnt_q <= '0;
                  run_q     <= 1'b1;
               end
            end
            ST_ARM: begin
               if (ack_s) state_q <= ST_COUNT;
            end
            ST_COUNT: begin
               if (win_cnt_q == n_lim_q - N_ONE) begin
                  state_q <= ST_STOP;
                  run_q   <= 1'b0;
               end else begin
                  win_cnt_q <= win_cnt_q + N_ONE;
               end
            end
            ST_STOP: begin
               if (!ack_s) begin
                  m_o     <= m_osc;
                  ovf_o   <= ovf_osc;
                  state_q <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o  = (state_q == ST_ARM) || (state_q == ST_COUNT) || (state_q == ST_STOP);
   assign valid_o = (state_q == ST_DONE);

   // R8: never busy and valid at once
   a_r8_busy_valid_excl: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !(busy_o && valid_o));

   // R5: a start during a measurement leaves the window length alone
   a_r5_ignore_busy_start: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || valid_o) && $stable(n_lim_q));

   // R7: a result is held until a new start
   a_r7_valid_holds: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (valid_o && !start_i) |=> (valid_o && $stable(m_o) && $stable(ovf_o)));

   // R6: a saturated result reads all ones
   a_r6_sat_value: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ovf_o |-> (m_o == '1));

   // R4: the window counter stays below the effective length, never zero
   a_r4_window_bound: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (state_q == ST_COUNT) |-> (n_lim_q != '0) && (win_cnt_q < n_lim_q));
endmodule

// File: tb/freq_gate_meter_test.sv
`timescale 1ns/1ps
module freq_gate_meter_test;
   localparam real REF_PER = 10.0;
   localparam int  N_W = 16;
   localparam int  M_W = 8;

   logic           ref_clk = 1'b0;
   logic           osc_clk = 1'b0;
   logic           rst_n   = 1'b0;
   logic           start_i = 1'b0;
   logic [N_W-1:0] n_i     = '0;
   logic           busy_o;
   logic           valid_o;
   logic [M_W-1:0] m_o;
   logic           ovf_o;

   real osc_half = 1.1;
   int  total = 0;
   int  bad   = 0;

   always #(REF_PER/2.0) ref_clk = ~ref_clk;
   always #(osc_half)    osc_clk = ~osc_clk;

   freq_gate_meter #(.N_W(N_W), .M_W(M_W), .PRE_LOG2(4), .SYNC_STAGES(2)) uut (
      .ref_clk (ref_clk),
      .osc_clk (osc_clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .n_i     (n_i),
      .busy_o  (busy_o),
      .valid_o (valid_o),
      .m_o     (m_o),
      .ovf_o   (ovf_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // one measurement; returns cycles from start edge to valid
   task automatic measure(input int n, output int lat);
      @(negedge ref_clk);
      start_i = 1'b1;
      n_i     = N_W'(n);
      @(negedge ref_clk);
      start_i = 1'b0;
      check(busy_o && !valid_o, "R2", "busy after start", {busy_o, valid_o}, 2);
      lat = 1;
      while (!valid_o && lat < 20000) begin
         check(!(busy_o && valid_o), "R8", "busy and valid", {busy_o, valid_o}, 2);
         @(negedge ref_clk);
         lat++;
      end
      check(valid_o && !busy_o, "R8", "valid without busy", {busy_o, valid_o}, 1);
   endtask

   function automatic real expect_m(input int n);
      return (n * REF_PER) / (16.0 * 2.0 * osc_half);
   endfunction

   task automatic check_m(input int n, input string req);
      real e;
      real d;
      e = expect_m(n);
      d = real'(m_o) - e;
      if (d < 0.0) d = -d;
      check(d <= 2.0, req, "count", int'(m_o), int'(e));
      check(ovf_o == 1'b0, "R6", "no overflow flag", int'(ovf_o), 0);
   endtask

   task automatic t_reset;
      check(!busy_o && !valid_o && !ovf_o && m_o == '0, "R1", "reset state",
            {busy_o, valid_o, ovf_o}, 0);
   endtask

   task automatic t_basic;
      int lat;
      osc_half = 1.1;
      measure(352, lat);
      check_m(352, "R3");
      measure(176, lat);
      check_m(176, "R3");
      osc_half = 2.2;
      measure(704, lat);
      check_m(704, "R3");
      osc_half = 1.1;
   endtask

   task automatic t_zero_window;
      int l0;
      int l1;
      int l8;
      measure(1, l1);
      measure(0, l0);
      measure(8, l8);
      check(l0 - l1 <= 1 && l1 - l0 <= 1, "R4", "N=0 latency vs N=1", l0, l1);
      check(l8 >= l0 + 5, "R4", "N=8 longer than N=0", l8, l0 + 7);
   endtask

   task automatic t_busy_start;
      @(negedge ref_clk);
      start_i = 1'b1;
      n_i     = N_W'(352);
      @(negedge ref_clk);
      start_i = 1'b0;
      repeat (20) @(negedge ref_clk);
      start_i = 1'b1;
      n_i     = N_W'(704);
      @(negedge ref_clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R5", "busy kept after second start", int'(busy_o), 1);
      for (int i = 0; i < 20000 && !valid_o; i++) @(negedge ref_clk);
      check_m(352, "R5");
   endtask

   task automatic t_overflow;
      int lat;
      measure(1000, lat);
      check(m_o == '1, "R6", "saturated count", int'(m_o), 255);
      check(ovf_o == 1'b1, "R6", "overflow flag", int'(ovf_o), 1);
   endtask

   task automatic t_hold;
      int lat;
      logic [M_W-1:0] held;
      measure(176, lat);
      held = m_o;
      repeat (60) @(negedge ref_clk);
      check(valid_o == 1'b1, "R7", "valid held", int'(valid_o), 1);
      check(m_o == held, "R7", "count held", int'(m_o), int'(held));
      start_i = 1'b1;
      n_i     = N_W'(176);
      @(negedge ref_clk);
      start_i = 1'b0;
      check(valid_o == 1'b0, "R7", "valid drops on start", int'(valid_o), 0);
      for (int i = 0; i < 20000 && !valid_o; i++) @(negedge ref_clk);
   endtask

   initial begin
      #(REF_PER * 200000.0);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge ref_clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge ref_clk);
      t_reset();
      t_basic();
      t_zero_window();
      t_busy_start();
      t_overflow();
      t_hold();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule